// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Responder

This block is the interrupt front end of a peripheral on a bus that supports vectored interrupts. A rising edge on the local event input marks the device as pending, and the device then pulls the shared active-low interrupt request line low. When the processor runs an acknowledge cycle, the device places an even vector byte on the data bus. The vector comes from a register that software writes. The device answers only when the priority chain above it is quiet, which means its chain input is high.

After it wins an acknowledge, the device counts as in service. While in service it keeps its chain output low, so that lower-priority devices cannot respond. It leaves that state when it sees the processor fetch the two-byte return-from-interrupt opcode. It does not decode the rest of the instruction stream. The data output is a value plus an enable, and a pad-level tri-state buffer outside this block uses the enable. All signals are synchronous to one clock.

Top module: `irqvec_node`

## Requirements
- R1: During and right after reset, the interrupt request is high, the data enable is low, the data output is 0x00, the vector register holds 0x00, and the chain output follows the chain input.
- R2: A low-to-high change on the event input sets pending on the next clock edge. While the device is pending, the interrupt request is low. Holding the event high does not set pending again after it has been cleared.
- R3: An acknowledge cycle is the condition where M1 and IORQ are both low. M1 low alone, or IORQ low alone, never enables the data output.
- R4: The data enable is high exactly when an acknowledge cycle is active, the chain input is high, and the device is pending.
- R5: While the data enable is high, the data output is the vector register with bit 0 forced to 0. While the data enable is low, the data output is 0x00.
- R6: The chain output is high only when the chain input is high and the device is neither pending nor in service.
- R7: When an acknowledge that the device drove comes to an end, the device clears pending and enters in service. The interrupt request returns high and the chain output stays low.
- R8: An opcode fetch is an M1 cycle with RD low and IORQ high, and its byte is sampled in the first cycle of M1 low. If a fetch of 0xED is followed by a fetch of 0x4D in the next M1 cycle, and the chain input is high, in service is cleared. Any other opcode between the two, an acknowledge between them, or a low chain input leaves in service set.
- R9: An event rising edge in the same cycle that a won acknowledge ends leaves the device pending, and also in service.
- R10: A register write stores bits 7:1 of the write data into the vector. Bit 0 of the write data has no effect on the vector that is driven, and a write takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Vector register write strobe |
| regWrData | input | 8 | Vector register write data |
| eventIn | input | 1 | Local interrupt event, captured on its rising edge |
| m1N | input | 1 | Active-low M1 (opcode fetch or acknowledge) |
| iorqN | input | 1 | Active-low I/O request |
| rdN | input | 1 | Active-low read strobe |
| dataIn | input | 8 | Snooped data bus |
| enIn | input | 1 | Chain enable from the higher-priority neighbour |
| enOut | output | 1 | Chain enable to the lower-priority neighbour |
| intReqN | output | 1 | Active-low interrupt request |
| dataOe | output | 1 | Output enable for the external data bus driver |
| dataOut | output | 8 | Vector byte for the data bus |

## Verification
Two updates to pending can land in the same cycle: a new event rising edge and the end of a won acknowledge. The bench provokes this by raising the event in the very cycle in which M1 and IORQ return high. It then expects pending and in service to both be set, with the request low and the chain output low. A second collision is a vector write during an active acknowledge. Here the driven byte must change exactly one cycle after the write. The bench judges every cycle against a behavioural model, and a mismatch on any output is reported.

// File: rtl/irqvec_pkg.sv
package irqvec_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadVec;
    logic driveBus;
  } irqStrobes_t;

  // opcode decode from datapath to control
  typedef struct packed {
    logic opPrefix;
    logic opReturn;
  } irqSnoop_t;
endpackage

// File: rtl/irqvec_dpath.sv
module irqvec_dpath
  import irqvec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RET_PREFIX = 8'hED,
  parameter logic [DATA_W-1:0] RET_CODE = 8'h4D
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobes_t       strobes,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] dataIn,
  output irqSnoop_t         snoop,
  output logic [DATA_W-1:0] dataOut
);
  localparam int VEC_W = DATA_W - 1;

  // only the upper bits are stored; bit 0 is always zero
  logic [VEC_W-1:0] vecHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                vecHigh <= '0;
    else if (strobes.loadVec) vecHigh <= regWrData[DATA_W-1:1];
  end

  always_comb begin
    dataOut = strobes.driveBus ? {vecHigh, 1'b0} : '0;
    snoop.opPrefix = (dataIn == RET_PREFIX);
    snoop.opReturn = (dataIn == RET_CODE);
  end
endmodule

// File: rtl/irqvec_ctrl.sv
module irqvec_ctrl
  import irqvec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        eventIn,
  input  logic        m1N,
  input  logic        iorqN,
  input  logic        rdN,
  input  logic        enIn,
  input  irqSnoop_t   snoop,
  output irqStrobes_t strobes,
  output logic        enOut,
  output logic        intReqN,
  output logic        dataOe
);
  logic eventPrev, m1Prev;
  logic pending, inService, wonAck, prefixSeen;
  logic ackCycle, evRise, ackDone, m1Start, opFetch, retSeen;

  always_comb begin
    ackCycle = !m1N && !iorqN;
    evRise   = eventIn && !eventPrev;
    ackDone  = wonAck && !ackCycle;
    m1Start  = !m1N && m1Prev;
    opFetch  = iorqN && !rdN;
    retSeen  = m1Start && opFetch && prefixSeen && snoop.opReturn;
    dataOe   = ackCycle && enIn && pending;
    intReqN  = !pending;
    enOut    = enIn && !pending && !inService;
    strobes.loadVec  = regWrEn;
    strobes.driveBus = dataOe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eventPrev  <= 1'b0;
      m1Prev     <= 1'b1;
      pending    <= 1'b0;
      inService  <= 1'b0;
      wonAck     <= 1'b0;
      prefixSeen <= 1'b0;
    end else begin
      eventPrev <= eventIn;
      m1Prev    <= m1N;
      // a fresh event wins over the acknowledge clearing pending
      if (evRise)       pending <= 1'b1;
      else if (ackDone) pending <= 1'b0;
      if (ackDone)                 inService <= 1'b1;
      else if (retSeen && enIn)    inService <= 1'b0;
      if (dataOe)         wonAck <= 1'b1;
      else if (!ackCycle) wonAck <= 1'b0;
      if (m1Start) prefixSeen <= opFetch && snoop.opPrefix;
    end
  end
endmodule

// File: rtl/irqvec_node.sv
module irqvec_node
  import irqvec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              eventIn,
  input  logic              m1N,
  input  logic              iorqN,
  input  logic              rdN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              enIn,
  output logic              enOut,
  output logic              intReqN,
  output logic              dataOe,
  output logic [DATA_W-1:0] dataOut
);
  irqStrobes_t strobes;
  irqSnoop_t   snoop;

  irqvec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .eventIn(eventIn),
    .m1N(m1N), .iorqN(iorqN), .rdN(rdN), .enIn(enIn), .snoop(snoop),
    .strobes(strobes), .enOut(enOut), .intReqN(intReqN), .dataOe(dataOe)
  );

  irqvec_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWrData(regWrData),
    .dataIn(dataIn), .snoop(snoop), .dataOut(dataOut)
  );
endmodule

// File: rtl/irqvec_checker.sv
module irqvec_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              m1N,
  input logic              iorqN,
  input logic              enIn,
  input logic              enOut,
  input logic              intReqN,
  input logic              dataOe,
  input logic [DATA_W-1:0] dataOut
);
  // R3: no drive unless M1 and IORQ are both low
  a_r3_no_drive_without_ack: assert property (@(posedge clk) disable iff (!rstN)
    (m1N || iorqN) |-> !dataOe);
  // R4: a low chain input blocks driving
  a_r4_chain_blocks_drive: assert property (@(posedge clk) disable iff (!rstN)
    !enIn |-> !dataOe);
  // R5: vector always even, quiet bus when idle
  a_r5_vector_even: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (dataOut[0] == 1'b0));
  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == '0));
  // R6: chain output low when input low or a request is pending
  a_r6_chain_follows: assert property (@(posedge clk) disable iff (!rstN)
    (!enIn || !intReqN) |-> !enOut);
  // R7: leaving the request state means in service, chain stays blocked
  a_r7_service_blocks: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intReqN) |-> !enOut);
  // R10: the driven vector only changes after a write
  a_r10_vector_stable: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && $past(dataOe) && !$past(regWrEn)) |-> $stable(dataOut));
endmodule

bind irqvec_node irqvec_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .m1N(m1N), .iorqN(iorqN),
  .enIn(enIn), .enOut(enOut), .intReqN(intReqN), .dataOe(dataOe),
  .dataOut(dataOut)
);

// File: tb/irqvec_node_bench.sv
`timescale 1ns/1ps
module irqvec_node_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic eventIn = 1'b0;
  logic m1N = 1'b1, iorqN = 1'b1, rdN = 1'b1;
  logic [7:0] dataIn = 8'h00;
  logic enIn = 1'b1;
  logic enOut, intReqN, dataOe;
  logic [7:0] dataOut;

  int nCmp = 0;
  int nBad = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  irqvec_node u_irqvec_node (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .eventIn(eventIn), .m1N(m1N), .iorqN(iorqN), .rdN(rdN), .dataIn(dataIn),
    .enIn(enIn), .enOut(enOut), .intReqN(intReqN), .dataOe(dataOe),
    .dataOut(dataOut)
  );

  // behavioural reference state
  bit mPend, mServ, mWon, mSawPrefix, mEvLast, mM1Last;
  bit [7:0] mVec;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPend = 0; mServ = 0; mWon = 0; mSawPrefix = 0;
      mEvLast = 0; mM1Last = 1; mVec = 8'h00;
    end else begin
      bit ack, finish, newM1, fetch, drove;
      ack    = !m1N && !iorqN;
      drove  = ack && enIn && mPend;
      finish = mWon && !ack;
      newM1  = !m1N && mM1Last;
      fetch  = iorqN && !rdN;
      if (newM1 && fetch && mSawPrefix && dataIn == 8'h4D && enIn) mServ = 0;
      if (finish) begin mServ = 1; mPend = 0; end
      if (eventIn && !mEvLast) mPend = 1;
      if (drove) mWon = 1; else if (!ack) mWon = 0;
      if (newM1) mSawPrefix = fetch && (dataIn == 8'hED);
      if (regWrEn) mVec = regWrData & 8'hFE;
      mEvLast = eventIn;
      mM1Last = m1N;
    end
  end

  task automatic check(string sig, string req, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s (%s) %s actual=%0h expected=%0h at %0t", req, curReq, sig, act, exp, $time);
    end
  endtask

  // compare late in the low phase, after inputs settled
  always @(negedge clk) begin
    #3;
    begin
      bit eOe;
      eOe = !m1N && !iorqN && enIn && mPend;
      check("intReqN", "R2", int'(intReqN), int'(!mPend));
      check("enOut", "R6", int'(enOut), int'(enIn && !mPend && !mServ));
      check("dataOe", "R4", int'(dataOe), int'(eOe));
      check("dataOut", "R5", int'(dataOut), eOe ? int'(mVec) : 0);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic busIdle();
    m1N = 1; iorqN = 1; rdN = 1;
  endtask

  task automatic ackCycle(int len);
    m1N = 0; iorqN = 0; rdN = 1; cyc(len); busIdle(); cyc(1);
  endtask

  task automatic fetchOp(logic [7:0] op);
    m1N = 0; iorqN = 1; rdN = 0; dataIn = op; cyc(2); busIdle(); cyc(1);
  endtask

  task automatic writeVec(logic [7:0] v);
    regWrEn = 1; regWrData = v; cyc(1); regWrEn = 0;
  endtask

  task automatic pulseEvent();
    eventIn = 1; cyc(1); eventIn = 0; cyc(1);
  endtask

  initial begin
    #(8 * 200000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    cyc(3);
    curReq = "R1"; // reset state
    check("intReqN", "R1", int'(intReqN), 1);
    check("dataOut", "R1", int'(dataOut), 0);
    rstN = 1; cyc(2);
    check("enOut", "R1", int'(enOut), 1);

    curReq = "R10"; // bit 0 of the write ignored
    writeVec(8'h37); cyc(1);

    curReq = "R2"; // edge capture, held level does not retrigger
    eventIn = 1; cyc(4);
    check("intReqN", "R2", int'(intReqN), 0);

    curReq = "R3"; // half-decoded cycles do not drive
    m1N = 0; iorqN = 1; rdN = 0; dataIn = 8'h00; cyc(2); busIdle(); cyc(1);
    m1N = 1; iorqN = 0; rdN = 0; cyc(2); busIdle(); cyc(1);
    check("dataOe", "R3", int'(dataOe), 0);

    curReq = "R4"; // chain input low blocks
    enIn = 0; ackCycle(3); enIn = 1; cyc(1);

    curReq = "R5"; // winning acknowledge drives 0x36
    m1N = 0; iorqN = 0; cyc(1);
    check("dataOut", "R5", int'(dataOut), 8'h36);
    cyc(2); busIdle(); cyc(1);

    curReq = "R7"; // now in service, event still held high
    check("intReqN", "R7", int'(intReqN), 1);
    check("enOut", "R7", int'(enOut), 0);
    eventIn = 0; cyc(2);

    curReq = "R8"; // ignored return sequences
    enIn = 0; fetchOp(8'hED); fetchOp(8'h4D); enIn = 1; cyc(1);
    fetchOp(8'hED); fetchOp(8'h00); fetchOp(8'h4D);
    fetchOp(8'hED); ackCycle(2); fetchOp(8'h4D);
    check("enOut", "R8", int'(enOut), 0);
    fetchOp(8'hED); fetchOp(8'h4D);
    check("enOut", "R8", int'(enOut), 1);

    curReq = "R9"; // event edge coincident with acknowledge end
    writeVec(8'hFF);
    pulseEvent();
    m1N = 0; iorqN = 0; cyc(2);
    busIdle(); eventIn = 1; cyc(1); eventIn = 0; cyc(1);
    check("intReqN", "R9", int'(intReqN), 0);
    check("enOut", "R9", int'(enOut), 0);

    curReq = "R10"; // write during acknowledge
    m1N = 0; iorqN = 0; cyc(1);
    check("dataOut", "R10", int'(dataOut), 8'hFE);
    regWrEn = 1; regWrData = 8'h41; cyc(1); regWrEn = 0;
    check("dataOut", "R10", int'(dataOut), 8'h40);
    cyc(1); busIdle(); cyc(1);
    fetchOp(8'hED); fetchOp(8'h4D); cyc(2);

    curReq = "R6"; // chain pass-through after full service
    enIn = 0; cyc(2); enIn = 1; cyc(2);
    check("enOut", "R6", int'(enOut), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule